// File: doc/BRIEF.md
# FFT Pass Block-Scaling Controller

This controller keeps the data of an in-place radix-2 FFT inside its 16-bit range by block floating-point scaling. The buffer sits in a local single-port data memory. An external pass sequencer asks for each butterfly pass with `pass_start` and reports its end with `pass_done`. While a pass runs, the controller watches every word that the butterfly datapath writes. It sets a sticky near-overflow flag whenever a written word has its two top bits unequal. The flag is cleared when a new pass is accepted.

When a pass ends with the flag set, the controller takes the memory port and sweeps the whole buffer. Each cycle it reads one word and writes it back shifted right by one place with the sign kept. When the sweep finishes, it signals that it is ready for the next pass. When a pass ends with the flag clear, no sweep runs. A block exponent counts the sweeps, so the true scale of the result is known at the end of the frame. The number of passes in a frame is log2 of the buffer length. After the final pass the controller does not scale, and it waits for the next frame start.

Top module: `fbs_scaler`

## Requirements
- R1: During a pass, a datapath write (`bf_wr_en` high) whose bit 15 differs from bit 14 sets `sticky` from the next cycle on. A write whose two top bits are equal leaves `sticky` unchanged.
- R2: Accepting a pass clears `sticky`. A datapath write made while no pass is running does not change `sticky`.
- R3: When `pass_done` arrives with `sticky` clear (counting a write in that same cycle), `pass_ready` is high again in the next cycle and no memory write happens.
- R4: When `pass_done` arrives in a pass other than the last with `sticky` set, the controller sweeps the buffer. `busy`, `mem_en` and `mem_we` stay high for exactly LEN cycles, one per word, at addresses 0 to LEN-1 in ascending order. Each word is written back as its arithmetic right shift by one (sign bit replicated), and `pass_ready` goes high in the cycle after the last word.
- R5: `pass_ready` is low while a pass or a sweep is in progress. A `pass_start` while `pass_ready` is low is ignored.
- R6: `block_exp` rises by exactly one for each pass that triggers a sweep, and is otherwise unchanged.
- R7: After the LOG2_LEN-th pass, no sweep happens even when `sticky` is set. `frame_done` goes high and `pass_ready` stays low until the next `frame_start`.
- R8: `frame_start` clears `block_exp`, `pass_idx` and `sticky`, and aborts any sweep or pass. In the next cycle `pass_ready` is high, and `busy` and `frame_done` are low.
- R9: `pass_idx` reports the number of passes completed in the current frame. It rises by one at each `pass_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Begins a new frame; clears exponent and pass count |
| pass_start | input | 1 | Sequencer request to begin a butterfly pass |
| pass_done | input | 1 | Sequencer report that the current pass has finished |
| bf_wr_en | input | 1 | Butterfly datapath writes a result this cycle |
| bf_wr_data | input | DATA_W | Value written by the butterfly datapath |
| mem_rdata | input | DATA_W | Memory read data, valid in the same cycle as `mem_addr` |
| pass_ready | output | 1 | A pass may be started |
| pass_idx | output | CNT_W | Passes completed in this frame |
| busy | output | 1 | Scaling sweep in progress |
| sticky | output | 1 | Sticky near-overflow flag for the current or last pass |
| block_exp | output | CNT_W | Number of scaling shifts applied in this frame |
| frame_done | output | 1 | All passes of the frame finished |
| mem_en | output | 1 | Memory access enable during the sweep |
| mem_we | output | 1 | Memory write enable during the sweep |
| mem_addr | output | LOG2_LEN | Sweep address |
| mem_wdata | output | DATA_W | Shifted word to write back |

## Verification
A corrupted sticky flag shows at the ports one cycle after the pass ends. Either a sweep starts that should not (`busy` rises and the memory changes), or `pass_ready` returns with words left unscaled. A corrupted sweep address or shift appears in the memory contents right after the LEN-cycle sweep, and the bench compares them word by word with shifted copies that it computes itself. A wrong pass or exponent count shows on `pass_idx` and `block_exp` at the next pass boundary. It also shows as `frame_done` rising one pass too early or too late.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
    typedef enum logic [1:0] {
        ST_READY = 2'd0,
        ST_PASS  = 2'd1,
        ST_SWEEP = 2'd2,
        ST_FIN   = 2'd3
    } fbs_state_e;
endpackage

// File: rtl/fbs_nearovf.sv
module fbs_nearovf #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word,
    output logic              near
);
    // top two bits disagree: one more doubling would overflow
    always_comb begin
        near = word[DATA_W-1] ^ word[DATA_W-2];
    end
endmodule

// File: rtl/fbs_ashr.sv
module fbs_ashr #(
    parameter int DATA_W = 16,
    parameter int SHIFT  = 1
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    generate
        if (SHIFT == 0) begin : g_pass
            always_comb dout = din;
        end else begin : g_shift
            always_comb dout = {{SHIFT{din[DATA_W-1]}}, din[DATA_W-1:SHIFT]};
        end
    endgenerate
endmodule

// File: rtl/fbs_sweep_addr.sv
module fbs_sweep_addr #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [AW-1:0] addr,
    output logic          last
);
    typedef struct packed {
        logic [AW-1:0] addr;
    } sa_reg_t;

    sa_reg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.addr = '0;
        end else if (en) begin
            r_d.addr = r_q.addr + AW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign addr = r_q.addr;
    assign last = (r_q.addr == {AW{1'b1}});

    AST_ADDR_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !last) |=> (addr == $past(addr) + AW'(1))); // R4
    AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && last) |=> (addr == '0)); // R4
endmodule

// File: rtl/fbs_scaler.sv
module fbs_scaler
    import fbs_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int LOG2_LEN = 5,
    parameter int CNT_W    = $clog2(LOG2_LEN + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                pass_start,
    input  logic                pass_done,
    input  logic                bf_wr_en,
    input  logic [DATA_W-1:0]   bf_wr_data,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                pass_ready,
    output logic [CNT_W-1:0]    pass_idx,
    output logic                busy,
    output logic                sticky,
    output logic [CNT_W-1:0]    block_exp,
    output logic                frame_done,
    output logic                mem_en,
    output logic                mem_we,
    output logic [LOG2_LEN-1:0] mem_addr,
    output logic [DATA_W-1:0]   mem_wdata
);
    localparam logic [CNT_W-1:0] LAST_PASS = CNT_W'(LOG2_LEN - 1);

    typedef struct packed {
        fbs_state_e       state;
        logic [CNT_W-1:0] pass_cnt;
        logic [CNT_W-1:0] exp;
        logic             sticky;
    } ctl_reg_t;

    ctl_reg_t r_q, r_d;

    logic                near_w;
    logic                hit_w;
    logic                addr_last_w;
    logic [LOG2_LEN-1:0] addr_w;
    logic                in_sweep_w;

    fbs_nearovf #(.DATA_W(DATA_W)) u_near (
        .word (bf_wr_data),
        .near (near_w)
    );

    fbs_ashr #(.DATA_W(DATA_W), .SHIFT(1)) u_shift (
        .din  (mem_rdata),
        .dout (mem_wdata)
    );

    assign in_sweep_w = (r_q.state == ST_SWEEP);

    fbs_sweep_addr #(.AW(LOG2_LEN)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_start || !in_sweep_w),
        .en    (in_sweep_w),
        .addr  (addr_w),
        .last  (addr_last_w)
    );

    assign hit_w = (r_q.state == ST_PASS) && bf_wr_en && near_w;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_READY: begin
                if (pass_start) begin
                    r_d.state  = ST_PASS;
                    r_d.sticky = 1'b0;
                end
            end
            ST_PASS: begin
                if (hit_w) begin
                    r_d.sticky = 1'b1;
                end
                if (pass_done) begin
                    r_d.pass_cnt = r_q.pass_cnt + CNT_W'(1);
                    if (r_q.pass_cnt == LAST_PASS) begin
                        r_d.state = ST_FIN;
                    end else if (r_q.sticky || hit_w) begin
                        r_d.state = ST_SWEEP;
                        r_d.exp   = r_q.exp + CNT_W'(1);
                    end else begin
                        r_d.state = ST_READY;
                    end
                end
            end
            ST_SWEEP: begin
                if (addr_last_w) begin
                    r_d.state = ST_READY;
                end
            end
            default: begin
            end
        endcase
        if (frame_start) begin
            r_d.state    = ST_READY;
            r_d.pass_cnt = '0;
            r_d.exp      = '0;
            r_d.sticky   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_READY, pass_cnt: '0, exp: '0, sticky: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pass_ready = (r_q.state == ST_READY);
    assign busy       = in_sweep_w;
    assign frame_done = (r_q.state == ST_FIN);
    assign sticky     = r_q.sticky;
    assign block_exp  = r_q.exp;
    assign pass_idx   = r_q.pass_cnt;
    assign mem_en     = in_sweep_w;
    assign mem_we     = in_sweep_w;
    assign mem_addr   = addr_w;

    AST_NEAR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_ready && !busy && !frame_done && bf_wr_en && !frame_start
         && (bf_wr_data[DATA_W-1] != bf_wr_data[DATA_W-2])) |=> sticky); // R1
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_ready && pass_start) |=> !sticky); // R2
    AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_ready && busy)); // R5
    AST_SWEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_start) |=> (busy || pass_ready)); // R5
    AST_EXP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> (block_exp == $past(block_exp)
                          || block_exp == $past(block_exp) + CNT_W'(1))); // R6
    AST_FIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_start) |=> (frame_done && !busy)); // R7
    AST_FRAME_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (pass_ready && block_exp == '0 && pass_idx == '0)); // R8
endmodule

// File: tb/fbs_scaler_test.sv
module fbs_scaler_test;
    localparam int DW   = 16;
    localparam int L2   = 3;
    localparam int LEN  = 1 << L2;
    localparam int CW   = $clog2(L2 + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          pass_start = 1'b0;
    logic          pass_done = 1'b0;
    logic          bf_wr_en = 1'b0;
    logic [DW-1:0] bf_wr_data = '0;
    logic [DW-1:0] mem_rdata;
    logic          pass_ready, busy, sticky, frame_done, mem_en, mem_we;
    logic [CW-1:0] pass_idx, block_exp;
    logic [L2-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    logic [DW-1:0] mem [LEN];
    logic [DW-1:0] gold [LEN];
    int errors = 0;
    int checks = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    fbs_scaler #(.DATA_W(DW), .LOG2_LEN(L2)) uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .pass_start(pass_start), .pass_done(pass_done),
        .bf_wr_en(bf_wr_en), .bf_wr_data(bf_wr_data), .mem_rdata(mem_rdata),
        .pass_ready(pass_ready), .pass_idx(pass_idx), .busy(busy),
        .sticky(sticky), .block_exp(block_exp), .frame_done(frame_done),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_mem();
        logic [DW-1:0] init [LEN] = '{16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF,
                                      16'h1234, 16'hC001, 16'h0002, 16'h4000};
        for (int i = 0; i < LEN; i++) begin
            mem[i]  = init[i];
            gold[i] = init[i];
        end
    endtask

    // runs one pass; writes w1 then w2 through the datapath monitor
    task automatic run_pass(input logic [DW-1:0] w1, input logic [DW-1:0] w2,
                            input string req);
        @(negedge clk);
        chk(pass_ready, req, "ready before pass", pass_ready, 1);
        pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
        chk(!pass_ready, "R5", "ready low in pass", pass_ready, 0);
        chk(!sticky, "R2", "sticky cleared at start", sticky, 0);
        bf_wr_en = 1'b1; bf_wr_data = w1;
        @(negedge clk);
        bf_wr_data = w2; pass_start = 1'b1;   // ignored: not ready
        @(negedge clk);
        bf_wr_en = 1'b0; pass_start = 1'b0;
        chk(!pass_ready && !busy, "R5", "start ignored mid-pass", pass_ready, 0);
        pass_done = 1'b1;
        @(negedge clk);
        pass_done = 1'b0;
    endtask

    task automatic t_reset();
        chk(pass_ready && !busy && !frame_done, "R8", "reset ready", pass_ready, 1);
        chk(block_exp == 0 && pass_idx == 0 && !sticky, "R8", "reset counters",
            block_exp, 0);
    endtask

    task automatic t_idle_write();
        @(negedge clk);
        bf_wr_en = 1'b1; bf_wr_data = 16'h4000;
        @(negedge clk);
        bf_wr_en = 1'b0;
        chk(!sticky, "R2", "idle write ignored", sticky, 0);
    endtask

    task automatic t_clean_pass();
        run_pass(16'h1234, 16'hC000, "R3");
        chk(!sticky, "R1", "equal top bits no flag", sticky, 0);
        chk(pass_ready && !busy, "R3", "ready after clean pass", pass_ready, 1);
        chk(pass_idx == 1, "R9", "pass_idx after pass 1", pass_idx, 1);
        chk(block_exp == 0, "R6", "exp unchanged", block_exp, 0);
        for (int i = 0; i < LEN; i++)
            chk(mem[i] == gold[i], "R3", "memory untouched", mem[i], gold[i]);
    endtask

    task automatic t_scale_pass();
        run_pass(16'h0100, 16'h8000, "R4");
        chk(sticky, "R1", "near-overflow flagged", sticky, 1);
        chk(block_exp == 1, "R6", "exp incremented", block_exp, 1);
        chk(pass_idx == 2, "R9", "pass_idx after pass 2", pass_idx, 2);
        for (int i = 0; i < LEN; i++) begin
            chk(busy && mem_we && mem_en, "R4", "busy during sweep", busy, 1);
            chk(mem_addr == L2'(i), "R4", "sweep address", mem_addr, i);
            chk(!pass_ready, "R5", "ready low in sweep", pass_ready, 0);
            @(negedge clk);
        end
        chk(!busy && pass_ready, "R4", "sweep ends after LEN", busy, 0);
        for (int i = 0; i < LEN; i++) begin
            logic [DW-1:0] e;
            e = DW'($signed(gold[i]) >>> 1);
            chk(mem[i] == e, "R4", "shifted word", mem[i], e);
            gold[i] = e;
        end
    endtask

    task automatic t_last_pass();
        run_pass(16'h4000, 16'h0000, "R7");
        chk(frame_done && !busy, "R7", "no sweep after last", busy, 0);
        chk(block_exp == 1 && pass_idx == 3, "R7", "exp kept at end", block_exp, 1);
        @(negedge clk);
        chk(!pass_ready && frame_done, "R7", "holds until frame", pass_ready, 0);
        for (int i = 0; i < LEN; i++)
            chk(mem[i] == gold[i], "R7", "memory kept", mem[i], gold[i]);
    endtask

    task automatic t_frame();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk(pass_ready && !frame_done && !busy, "R8", "frame restart", pass_ready, 1);
        chk(block_exp == 0 && pass_idx == 0 && !sticky, "R8", "frame clears",
            block_exp, 0);
    endtask

    task automatic t_abort();
        run_pass(16'hBFFF, 16'h0000, "R8");
        chk(busy, "R4", "sweep started", busy, 1);
        @(negedge clk); @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        chk(!busy && pass_ready, "R8", "sweep aborted", busy, 0);
        chk(block_exp == 0, "R8", "exp cleared on abort", block_exp, 0);
        @(negedge clk);
        chk(!mem_we, "R8", "no writes after abort", mem_we, 0);
    endtask

    initial begin
        load_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_write();
        t_clean_pass();
        t_scale_pass();
        t_last_pass();
        t_frame();
        t_abort();
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=hung expected=finish");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule